// File: doc/BRIEF.md
# Pointer-Addressed I2C Register Target

This block is an I2C target that gives a bus master access to a small bank of 16-bit registers. The first byte a master writes after the address is taken as a register pointer. Later bytes in that write land in the register the pointer selects, as most-significant/least-significant pairs. A read returns the selected register, most significant byte first. The pointer stays in place between transactions, so a master can poll one register by sending only read transactions.

The SCL and SDA inputs must already be filtered and synchronised to the system clock. The block detects edges, START and STOP on them and drives an open-drain pull-down enable for SDA. Three address-select pins form the low bits of the 7-bit target address. They are sampled at reset and again on a general-call command, and the general-call reset command also restores every register to its power-up value. A high-speed master code is recognised, left unacknowledged and reported on a mode flag. A local port lets on-chip logic read and write the same registers.

Top module: `i2c_ptr_target`

## Requirements
- R1: While reset is high and after it is released, `sda_oe` and `hs_mode` are 0 and the pointer is 0. Register i holds its power-up value 16'h5A00 + i.
- R2: The target address is {4'b1001, latched pins}. Byte 1 after START is {address, rw}, with rw=1 for read and rw=0 for write. A matching address is acknowledged (SDA low in the ninth clock) for reads and for writes. Any other address is not acknowledged, and the rest of that transaction has no effect.
- R3: In a write, the byte after the address becomes the pointer, taken modulo NUM_REGS and acknowledged. A write that ends after the pointer byte is valid and only moves the pointer.
- R4: In a write, the data bytes after the pointer form MSB/LSB pairs, and each byte is acknowledged. Each full pair is committed as one 16-bit value to the pointed register. Later pairs in the same write go to the same register.
- R5: A read sends the MSB and then the LSB of the pointed register. The pointer from the last write is kept across any number of transactions. If the master acknowledges the LSB, the MSB follows again.
- R6: When the master leaves a read byte unacknowledged, the block releases SDA and drives nothing until the next START.
- R7: The general-call write address (first byte 8'h00) is acknowledged. Command byte 8'h04 re-samples the address pins and changes no register or pointer. Any command other than 8'h04 or 8'h06 is not acknowledged.
- R8: General-call command 8'h06 re-samples the address pins, restores all registers to their power-up values and clears the pointer.
- R9: A first byte of the form 8'b00001xxx after a START is not acknowledged. It sets `hs_mode`, which stays set through repeated STARTs until the next STOP.
- R10: `sda_oe` changes only while SCL is low. SDA is sampled on the rising edge of SCL.
- R11: The local port writes a register when `loc_we` is high and reads the register at `loc_addr` combinationally. When a bus commit and a local write hit the same register in the same cycle, the bus value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised SCL line |
| sda_i | input | 1 | Synchronised SDA line (wired level) |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_pins_i | input | PIN_W | Address-select pins |
| loc_we | input | 1 | Local write strobe |
| loc_addr | input | IDX_W | Local register index |
| loc_wdata | input | 16 | Local write data |
| loc_rdata | output | 16 | Local read data |
| hs_mode | output | 1 | High-speed master code seen since last STOP |

## Verification
A bus commit of a completed MSB/LSB pair and a local-port write can land on the same register in the same clock cycle. The bench provokes this by asserting `loc_we` to the pointed register exactly one clock after it raises SCL for the last bit of the LSB, which is the cycle the commit reaches the register file. It judges the outcome by reading the register back through the local port and expecting the bus value, and the checker asserts the same priority on every such overlap.

// File: rtl/i2cpt_pkg.sv
package i2cpt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_TXACK
    } state_t;

    typedef enum logic [2:0] {
        K_ADDR,
        K_PTR,
        K_MSB,
        K_LSB,
        K_GC,
        K_IGN
    } kind_t;

    localparam logic [7:0] GC_ADDR  = 8'h00;
    localparam logic [7:0] GC_LATCH = 8'h04;
    localparam logic [7:0] GC_RESET = 8'h06;
    localparam logic [4:0] HS_CODE  = 5'b00001;

    function automatic logic [15:0] por_value(input int idx);
        return 16'h5A00 + 16'(idx);
    endfunction

endpackage

// File: rtl/i2cpt_edges.sv
module i2cpt_edges (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise  = scl_i & ~scl_q;
    assign scl_fall  = ~scl_i & scl_q;
    assign start_det = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/i2cpt_regs.sv
module i2cpt_regs
    import i2cpt_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             bus_we,
    input  logic [IDX_W-1:0] bus_idx,
    input  logic [15:0]      bus_wdata,
    output logic [15:0]      bus_rdata,
    input  logic             loc_we,
    input  logic [IDX_W-1:0] loc_idx,
    input  logic [15:0]      loc_wdata,
    output logic [15:0]      loc_rdata
);
    logic [15:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                regs[g] <= por_value(g);
            end else if (bus_we && bus_idx == IDX_W'(g)) begin
                regs[g] <= bus_wdata;
            end else if (loc_we && loc_idx == IDX_W'(g)) begin
                regs[g] <= loc_wdata;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        loc_rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (bus_idx == IDX_W'(i)) bus_rdata = regs[i];
            if (loc_idx == IDX_W'(i)) loc_rdata = regs[i];
        end
    end

endmodule

// File: rtl/i2cpt_ctrl.sv
module i2cpt_ctrl
    import i2cpt_pkg::*;
#(
    parameter int               NUM_REGS   = 4,
    parameter int               IDX_W      = $clog2(NUM_REGS),
    parameter int               PIN_W      = 3,
    parameter logic [6-PIN_W:0] ADDR_FIXED = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             sda_i,
    input  logic [PIN_W-1:0] pins_i,
    input  logic [15:0]      rd_data,
    output logic [IDX_W-1:0] ptr_o,
    output logic             wr_en_o,
    output logic [15:0]      wr_data_o,
    output logic             clr_o,
    output logic             sda_oe_o,
    output logic             hs_mode_o
);
    state_t           st;
    kind_t            kind;
    logic [7:0]       sh;
    logic [3:0]       cnt;
    logic             full;
    logic             ack_ok;
    logic             go_tx;
    logic [7:0]       msb_q;
    logic             lsb_next;
    logic             acked;
    logic [PIN_W-1:0] pins_q;

    logic [7:0] rx_byte;
    logic [6:0] my_addr;
    logic       dec_ack;
    logic       dec_tx;
    logic       dec_hs;
    kind_t      dec_kind;

    assign rx_byte = {sh[6:0], sda_i};
    assign my_addr = {ADDR_FIXED, pins_q};

    // Decision for the byte that completes on this SCL rising edge
    always_comb begin
        dec_ack  = 1'b0;
        dec_tx   = 1'b0;
        dec_hs   = 1'b0;
        dec_kind = K_IGN;
        case (kind)
            K_ADDR: begin
                if (rx_byte[7:3] == HS_CODE) begin
                    dec_hs = 1'b1;
                end else if (rx_byte[7:1] == my_addr) begin
                    dec_ack  = 1'b1;
                    dec_tx   = rx_byte[0];
                    dec_kind = K_PTR;
                end else if (rx_byte == GC_ADDR) begin
                    dec_ack  = 1'b1;
                    dec_kind = K_GC;
                end
            end
            K_PTR: begin dec_ack = 1'b1; dec_kind = K_MSB; end
            K_MSB: begin dec_ack = 1'b1; dec_kind = K_LSB; end
            K_LSB: begin dec_ack = 1'b1; dec_kind = K_MSB; end
            K_GC:  dec_ack = (rx_byte == GC_LATCH) || (rx_byte == GC_RESET);
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        wr_en_o <= 1'b0;
        clr_o   <= 1'b0;
        if (rst) begin
            st        <= ST_IDLE;
            kind      <= K_ADDR;
            sh        <= '0;
            cnt       <= '0;
            full      <= 1'b0;
            ack_ok    <= 1'b0;
            go_tx     <= 1'b0;
            msb_q     <= '0;
            lsb_next  <= 1'b0;
            acked     <= 1'b0;
            ptr_o     <= '0;
            wr_data_o <= '0;
            hs_mode_o <= 1'b0;
            pins_q    <= pins_i;
        end else if (stop_det) begin
            st        <= ST_IDLE;
            hs_mode_o <= 1'b0;
        end else if (start_det) begin
            st   <= ST_RX;
            kind <= K_ADDR;
            cnt  <= '0;
            full <= 1'b0;
        end else begin
            case (st)
                ST_RX: begin
                    if (scl_rise && !full) begin
                        sh  <= rx_byte;
                        cnt <= cnt + 4'd1;
                        if (cnt == 4'd7) begin
                            full   <= 1'b1;
                            ack_ok <= dec_ack;
                            go_tx  <= dec_tx;
                            kind   <= dec_kind;
                            if (dec_hs) hs_mode_o <= 1'b1;
                            case (kind)
                                K_PTR: ptr_o <= IDX_W'(rx_byte % 8'(NUM_REGS));
                                K_MSB: msb_q <= rx_byte;
                                K_LSB: begin
                                    wr_en_o   <= 1'b1;
                                    wr_data_o <= {msb_q, rx_byte};
                                end
                                K_GC: begin
                                    if (rx_byte == GC_LATCH || rx_byte == GC_RESET)
                                        pins_q <= pins_i;
                                    if (rx_byte == GC_RESET) begin
                                        clr_o <= 1'b1;
                                        ptr_o <= '0;
                                    end
                                end
                                default: ;
                            endcase
                        end
                    end else if (scl_fall && full) begin
                        full <= 1'b0;
                        cnt  <= '0;
                        st   <= ack_ok ? ST_ACK : ST_IDLE;
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (go_tx) begin
                            st       <= ST_TX;
                            sh       <= rd_data[15:8];
                            lsb_next <= 1'b1;
                        end else begin
                            st <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        cnt <= cnt + 4'd1;
                        if (cnt == 4'd7) full <= 1'b1;
                    end else if (scl_fall) begin
                        if (full) begin
                            full  <= 1'b0;
                            acked <= 1'b0;
                            st    <= ST_TXACK;
                        end else begin
                            sh <= {sh[6:0], 1'b0};
                        end
                    end
                end
                ST_TXACK: begin
                    if (scl_rise) begin
                        if (sda_i) st <= ST_IDLE;
                        else       acked <= 1'b1;
                    end else if (scl_fall && acked) begin
                        st       <= ST_TX;
                        cnt      <= '0;
                        sh       <= lsb_next ? rd_data[7:0] : rd_data[15:8];
                        lsb_next <= ~lsb_next;
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_oe_o = (st == ST_ACK) || (st == ST_TX && !sh[7]);

endmodule

// File: rtl/i2c_ptr_target.sv
module i2c_ptr_target
    import i2cpt_pkg::*;
#(
    parameter int               NUM_REGS   = 4,
    parameter int               PIN_W      = 3,
    parameter logic [6-PIN_W:0] ADDR_FIXED = 4'b1001,
    localparam int              IDX_W      = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic [PIN_W-1:0] addr_pins_i,
    input  logic             loc_we,
    input  logic [IDX_W-1:0] loc_addr,
    input  logic [15:0]      loc_wdata,
    output logic [15:0]      loc_rdata,
    output logic             hs_mode
);
    logic             scl_rise;
    logic             scl_fall;
    logic             start_det;
    logic             stop_det;
    logic [IDX_W-1:0] bus_ptr;
    logic             bus_we;
    logic [15:0]      bus_wdata;
    logic [15:0]      bus_rdata;
    logic             clr;

    i2cpt_edges u_edges (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cpt_ctrl #(
        .NUM_REGS   (NUM_REGS),
        .IDX_W      (IDX_W),
        .PIN_W      (PIN_W),
        .ADDR_FIXED (ADDR_FIXED)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_i     (sda_i),
        .pins_i    (addr_pins_i),
        .rd_data   (bus_rdata),
        .ptr_o     (bus_ptr),
        .wr_en_o   (bus_we),
        .wr_data_o (bus_wdata),
        .clr_o     (clr),
        .sda_oe_o  (sda_oe),
        .hs_mode_o (hs_mode)
    );

    i2cpt_regs #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .bus_we    (bus_we),
        .bus_idx   (bus_ptr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .loc_we    (loc_we),
        .loc_idx   (loc_addr),
        .loc_wdata (loc_wdata),
        .loc_rdata (loc_rdata)
    );

endmodule

// File: rtl/i2cpt_checker.sv
module i2cpt_checker
    import i2cpt_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             scl_i,
    input logic             sda_oe,
    input logic             hs_mode,
    input logic             stop_det,
    input logic             clr,
    input logic             bus_we,
    input logic [IDX_W-1:0] bus_ptr,
    input logic [15:0]      bus_wdata,
    input logic             loc_we,
    input logic [IDX_W-1:0] loc_addr,
    input logic [15:0]      loc_rdata
);
    AST_RST_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!sda_oe && !hs_mode)); // R1

    AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !$past(scl_i)); // R10

    AST_HS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !hs_mode); // R9

    AST_HS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (hs_mode && !stop_det) |=> hs_mode); // R9

    AST_BUS_WINS: assert property (@(posedge clk) disable iff (rst)
        (bus_we && loc_we && loc_addr == bus_ptr)
        |=> (!$stable(loc_addr) || loc_rdata == $past(bus_wdata))); // R11

    AST_CLR_POR: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!$stable(loc_addr) || loc_rdata == por_value(int'(loc_addr)))); // R8

endmodule

bind i2c_ptr_target i2cpt_checker #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .hs_mode   (hs_mode),
    .stop_det  (stop_det),
    .clr       (clr),
    .bus_we    (bus_we),
    .bus_ptr   (bus_ptr),
    .bus_wdata (bus_wdata),
    .loc_we    (loc_we),
    .loc_addr  (loc_addr),
    .loc_rdata (loc_rdata)
);

// File: tb/i2c_ptr_target_tb.sv
`timescale 1ns/1ps
module i2c_ptr_target_tb;
    localparam int NREG = 4;
    localparam int IW   = 2;
    localparam int HALF = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          scl = 1'b1;
    logic          sda_m = 1'b1;
    logic          sda_bus;
    logic          sda_oe;
    logic [2:0]    pins = 3'b010;
    logic          loc_we = 1'b0;
    logic [IW-1:0] loc_addr = '0;
    logic [15:0]   loc_wdata = '0;
    logic [15:0]   loc_rdata;
    logic          hs_mode;

    int n_checks = 0;
    int n_err    = 0;
    int oe_bad   = 0;
    bit done     = 1'b0;

    string      exp_req_q[$];
    logic [7:0] exp_q[$];
    logic [7:0] obs_q[$];

    always #4 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    i2c_ptr_target u_dut (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl),
        .sda_i       (sda_bus),
        .sda_oe      (sda_oe),
        .addr_pins_i (pins),
        .loc_we      (loc_we),
        .loc_addr    (loc_addr),
        .loc_wdata   (loc_wdata),
        .loc_rdata   (loc_rdata),
        .hs_mode     (hs_mode)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: pairs each observed read byte with the queued expectation
    initial forever begin
        @(negedge clk);
        while (obs_q.size() > 0) begin
            logic [7:0] o;
            o = obs_q.pop_front();
            if (exp_q.size() == 0) begin
                chk("R5 unexpected byte", 16'(o), 16'hFFFF);
            end else begin
                chk(exp_req_q.pop_front(), 16'(o), 16'(exp_q.pop_front()));
            end
        end
    end

    // R10: SDA drive may only change while SCL is low
    initial begin
        logic prev_oe;
        prev_oe = 1'b0;
        forever begin
            @(posedge clk);
            #2;
            if (!rst && sda_oe !== prev_oe && scl) oe_bad++;
            prev_oe = sda_oe;
        end
    end

    task automatic hold();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hold(); scl = 1'b1; hold(); sda_m = 1'b0; hold(); scl = 1'b0;
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold(); scl = 1'b1; hold(); sda_m = 1'b1; hold();
    endtask

    task automatic write_byte(input logic [7:0] b, input bit collide, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i];
            hold();
            scl = 1'b1;
            if (collide && i == 0) begin
                @(negedge clk); loc_we = 1'b1;
                @(negedge clk); loc_we = 1'b0;
                repeat (HALF - 2) @(negedge clk);
            end else begin
                hold();
            end
            scl = 1'b0;
        end
        sda_m = 1'b1;
        hold();
        scl = 1'b1;
        hold();
        ack = !sda_bus;
        scl = 1'b0;
    endtask

    task automatic read_byte(input bit mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hold();
            scl = 1'b1;
            hold();
            b[i] = sda_bus;
            scl = 1'b0;
        end
        sda_m = !mack;
        hold();
        scl = 1'b1;
        hold();
        scl = 1'b0;
        sda_m = 1'b1;
    endtask

    task automatic send(input logic [7:0] b, input bit exp_ack, input string req);
        bit a;
        write_byte(b, 1'b0, a);
        chk(req, 16'(a), 16'(exp_ack));
    endtask

    task automatic expect_read(input bit mack, input logic [7:0] exp, input string req);
        logic [7:0] b;
        exp_req_q.push_back(req);
        exp_q.push_back(exp);
        read_byte(mack, b);
        obs_q.push_back(b);
    endtask

    task automatic loc_chk(input int idx, input logic [15:0] exp, input string req);
        @(negedge clk);
        loc_addr = IW'(idx);
        @(negedge clk);
        chk(req, loc_rdata, exp);
    endtask

    task automatic loc_write(input int idx, input logic [15:0] d);
        @(negedge clk);
        loc_addr = IW'(idx); loc_wdata = d; loc_we = 1'b1;
        @(negedge clk);
        loc_we = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bit a;
        repeat (5) @(negedge clk);
        // R1: reset state
        chk("R1 sda_oe in reset", 16'(sda_oe), 16'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 sda_oe after reset", 16'(sda_oe), 16'h0);
        chk("R1 hs_mode after reset", 16'(hs_mode), 16'h0);
        for (int i = 0; i < NREG; i++) loc_chk(i, 16'h5A00 + 16'(i), "R1 power-up value");

        // R1/R5: read with the reset pointer (0)
        bus_start();
        send(8'h95, 1'b1, "R2 read address ack");
        expect_read(1'b1, 8'h5A, "R5 msb first");
        expect_read(1'b0, 8'h00, "R5 lsb second");
        bus_stop();

        // R4: pointer 2, one pair
        bus_start();
        send(8'h94, 1'b1, "R2 write address ack");
        send(8'h02, 1'b1, "R3 pointer ack");
        send(8'h12, 1'b1, "R4 msb ack");
        send(8'h34, 1'b1, "R4 lsb ack");
        bus_stop();
        loc_chk(2, 16'h1234, "R4 committed pair");

        // R3/R5: pointer-only write, repeated start read, wrap to MSB
        bus_start();
        send(8'h94, 1'b1, "R3 address ack");
        send(8'h01, 1'b1, "R3 pointer-only ack");
        bus_start();
        send(8'h95, 1'b1, "R5 read after repeated start");
        expect_read(1'b1, 8'h5A, "R5 msb of reg1");
        expect_read(1'b1, 8'h01, "R5 lsb of reg1");
        expect_read(1'b0, 8'h5A, "R5 msb repeats after acked lsb");
        bus_stop();
        bus_start();
        send(8'h95, 1'b1, "R5 read again");
        expect_read(1'b1, 8'h5A, "R5 pointer persists msb");
        expect_read(1'b0, 8'h01, "R5 pointer persists lsb");
        bus_stop();

        // R3 wrap (7 mod 4 = 3), R4 two pairs to same register
        bus_start();
        send(8'h94, 1'b1, "R3 address ack");
        send(8'h07, 1'b1, "R3 wrapped pointer ack");
        send(8'hAB, 1'b1, "R4 pair1 msb");
        send(8'hCD, 1'b1, "R4 pair1 lsb");
        send(8'h11, 1'b1, "R4 pair2 msb");
        send(8'h22, 1'b1, "R4 pair2 lsb");
        bus_stop();
        loc_chk(3, 16'h1122, "R4 last pair in reg3");
        loc_chk(2, 16'h1234, "R3 reg2 untouched by wrap");

        // R2: foreign address is ignored
        bus_start();
        send(8'h96, 1'b0, "R2 foreign address nack");
        send(8'h00, 1'b0, "R2 ignored byte");
        send(8'h77, 1'b0, "R2 ignored byte");
        send(8'h77, 1'b0, "R2 ignored byte");
        bus_stop();
        loc_chk(0, 16'h5A00, "R2 reg0 untouched");
        loc_chk(3, 16'h1122, "R2 reg3 untouched");

        // R6: master NACK on the MSB releases SDA
        bus_start();
        send(8'h95, 1'b1, "R6 address ack");
        expect_read(1'b0, 8'h11, "R6 msb of reg3");
        hold();
        chk("R6 sda released", 16'(sda_oe), 16'h0);
        bus_stop();

        // R11: local write, then bus read of it
        loc_write(0, 16'hC0DE);
        loc_chk(0, 16'hC0DE, "R11 local write");
        bus_start();
        send(8'h94, 1'b1, "R11 address ack");
        send(8'h00, 1'b1, "R11 pointer ack");
        bus_start();
        send(8'h95, 1'b1, "R11 read ack");
        expect_read(1'b1, 8'hC0, "R11 bus sees local msb");
        expect_read(1'b0, 8'hDE, "R11 bus sees local lsb");
        bus_stop();

        // R11: same-cycle collision, bus wins
        loc_addr = IW'(1);
        loc_wdata = 16'h0F0F;
        bus_start();
        send(8'h94, 1'b1, "R11 address ack");
        send(8'h01, 1'b1, "R11 pointer ack");
        send(8'hBE, 1'b1, "R11 msb ack");
        write_byte(8'hEF, 1'b1, a);
        chk("R11 colliding lsb ack", 16'(a), 16'h1);
        bus_stop();
        loc_chk(1, 16'hBEEF, "R11 bus value wins");

        // R7: general call latch
        pins = 3'b101;
        bus_start();
        send(8'h9A, 1'b0, "R7 new pins not yet latched");
        bus_stop();
        bus_start();
        send(8'h00, 1'b1, "R7 general call ack");
        send(8'h04, 1'b1, "R7 latch command ack");
        bus_stop();
        loc_chk(1, 16'hBEEF, "R7 registers kept");
        bus_start();
        send(8'h9B, 1'b1, "R7 new address ack");
        expect_read(1'b1, 8'hBE, "R7 pointer kept msb");
        expect_read(1'b0, 8'hEF, "R7 pointer kept lsb");
        bus_stop();
        bus_start();
        send(8'h94, 1'b0, "R7 old address nack");
        bus_stop();
        bus_start();
        send(8'h00, 1'b1, "R7 general call ack");
        send(8'h05, 1'b0, "R7 unknown command nack");
        bus_stop();

        // R8: general call reset
        pins = 3'b011;
        bus_start();
        send(8'h00, 1'b1, "R8 general call ack");
        send(8'h06, 1'b1, "R8 reset command ack");
        bus_stop();
        for (int i = 0; i < NREG; i++) loc_chk(i, 16'h5A00 + 16'(i), "R8 power-up restored");
        bus_start();
        send(8'h97, 1'b1, "R8 relatched address ack");
        expect_read(1'b1, 8'h5A, "R8 pointer cleared msb");
        expect_read(1'b0, 8'h00, "R8 pointer cleared lsb");
        bus_stop();

        // R9: high-speed master code
        bus_start();
        send(8'h0A, 1'b0, "R9 master code nack");
        chk("R9 hs_mode set", 16'(hs_mode), 16'h1);
        bus_start();
        send(8'h96, 1'b1, "R9 address after code");
        send(8'h02, 1'b1, "R9 pointer in hs mode");
        chk("R9 hs_mode held", 16'(hs_mode), 16'h1);
        bus_stop();
        chk("R9 hs_mode cleared by stop", 16'(hs_mode), 16'h0);

        repeat (4) @(negedge clk);
        chk("R10 drive changes with scl high", 16'(oe_bad), 16'h0);
        chk("R5 scoreboard drained", 16'(exp_q.size()), 16'h0);
        finish_run();
    end

endmodule